// File: doc/BRIEF.md
# L2 Way Memo Store

This block is a small array kept beside an L1 data cache. It has one entry for each L1 line. The entry records which of the four ways of a write-through L2 cache holds the copy of that line. It uses the same line index as the L1 data array, so it is looked up in the same cycle as that array. When the L2 delivers a line to fill the L1, the controller writes the way that supplied the line. When the L1 later performs a write, the entry is read out. A valid result lets the L2 write enable a single way. An invalid result means every way must be enabled.

The way that supplied a fill is first captured in a way register. A fill commits the registered way into the addressed entry. Evicting or invalidating an L1 line clears that entry's valid bit. L1 reads never touch the array.

Top module: `way_memo_top`

## Requirements
- R1: After reset every entry is invalid, and a lookup of any index returns valid_o=0 and way_o=2'b00.
- R2: A lookup is performed only when wr_op_i=1 (an L1 write) and upd_i=0. Its result appears on valid_o/way_o one clock after the request and is held until the next lookup.
- R3: A fill happens when wr_op_i=1 and upd_i=1. It writes the contents of the way register into the entry at idx_i and sets that entry valid.
- R4: The way register loads l2_way_i on any cycle with way_ld_i=1. A fill in the same cycle stores the newly presented l2_way_i (bypass).
- R5: L2 ways are encoded in 2 bits, 00 to 11 for ways 0 to 3. A valid lookup returns the exact code last filled at that index.
- R6: A request with wr_op_i=0 (an L1 read) neither reads nor writes the array. valid_o, way_o and all entries stay unchanged.
- R7: inv_i=1 clears the valid bit of the entry at inv_idx_i. If inv_i and a fill hit the same index in one cycle, the fill wins.
- R8: Entry count is L1_BYTES/LINE_BYTES (default 64). A fill to one index leaves every other entry unchanged.
- R9: way_en_o is one-hot at the stored way after a valid lookup and 4'b1111 after an invalid one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_i | input | 1 | L1 access strobe |
| wr_op_i | input | 1 | 1 = L1 write or fill, 0 = L1 read |
| upd_i | input | 1 | fill update from the cache controller |
| idx_i | input | IDX_W | L1 line index |
| way_ld_i | input | 1 | load the way register |
| l2_way_i | input | 2 | L2 way that supplied the line |
| inv_i | input | 1 | eviction or invalidation strobe |
| inv_idx_i | input | IDX_W | index to invalidate |
| valid_o | output | 1 | lookup found a known way |
| way_o | output | 2 | stored way code |
| way_en_o | output | 4 | L2 way enables |

## Verification
A corrupted entry or a stuck valid bit shows on the next lookup of that index, one cycle after the request. It appears as a wrong way_o or a wrong valid_o. A lost invalidate shows up as a stale valid hit. A spurious access on an L1 read shows up as a changed output on the following cycle. The bench keeps a shadow model of all entries and compares every lookup against it.

// File: rtl/way_memo_pkg.sv
package way_memo_pkg;
  localparam int unsigned L2_WAYS = 4;
  localparam int unsigned WAY_W   = $clog2(L2_WAYS);
  typedef logic [WAY_W-1:0] way_t;
  typedef struct packed {
    logic valid;
    way_t way;
  } memo_t;
endpackage

// File: rtl/way_reg.sv
module way_reg
  import way_memo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  way_t way_i,
  output way_t way_o
);
  way_t q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else if (ld_i) q <= way_i;
  // bypass so a same-cycle load feeds the fill
  assign way_o = ld_i ? way_i : q;
endmodule

// File: rtl/memo_array.sv
module memo_array
  import way_memo_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  way_t             wway_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] ridx_i,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  output memo_t            rd_o
);
  way_t way_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  memo_t rd_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hit_w, hit_i;
    assign hit_w = we_i && (widx_i == IDX_W'(g));
    assign hit_i = inv_i && (inv_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        way_q[g] <= '0;
      end else if (hit_w) begin
        vld_q[g] <= 1'b1;
        way_q[g] <= wway_i;
      end else if (hit_i) begin
        vld_q[g] <= 1'b0;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rd_q <= '0;
    else if (re_i) begin
      rd_q.valid <= vld_q[ridx_i];
      rd_q.way   <= vld_q[ridx_i] ? way_q[ridx_i] : '0;
    end
  assign rd_o = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rd_o)) else $error("read port moved"); // R6
  AST_FILL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q[$past(widx_i)]) else $error("fill lost"); // R3
  AST_INV_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && !(we_i && widx_i == inv_idx_i)) |=> !vld_q[$past(inv_idx_i)])
    else $error("invalidate lost"); // R7
endmodule

// File: rtl/way_dec.sv
module way_dec
  import way_memo_pkg::*;
(
  input  logic               valid_i,
  input  way_t               way_i,
  output logic [L2_WAYS-1:0] en_o
);
  always_comb begin
    en_o = '1;
    if (valid_i) begin
      en_o = '0;
      en_o[way_i] = 1'b1;
    end
  end
endmodule

// File: rtl/way_memo_top.sv
module way_memo_top
  import way_memo_pkg::*;
#(
  parameter int unsigned L1_BYTES   = 4096,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned ENTRIES   = L1_BYTES / LINE_BYTES,
  localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_op_i,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             way_ld_i,
  input  logic [1:0]       l2_way_i,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  output logic             valid_o,
  output logic [1:0]       way_o,
  output logic [3:0]       way_en_o
);
  way_t  fill_way;
  memo_t rd;
  logic  fill, look;

  assign fill = req_i && wr_op_i && upd_i;
  assign look = req_i && wr_op_i && !upd_i;

  way_reg u_reg (
    .clk_i, .rst_ni, .ld_i(way_ld_i), .way_i(l2_way_i), .way_o(fill_way)
  );

  memo_array #(.ENTRIES(ENTRIES)) u_arr (
    .clk_i, .rst_ni,
    .we_i(fill), .widx_i(idx_i), .wway_i(fill_way),
    .re_i(look), .ridx_i(idx_i),
    .inv_i, .inv_idx_i,
    .rd_o(rd)
  );

  way_dec u_dec (.valid_i(rd.valid), .way_i(rd.way), .en_o(way_en_o));

  assign valid_o = rd.valid;
  assign way_o   = rd.way;

  AST_EN_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o ? $onehot0(way_en_o) && way_en_o != 4'b0 : way_en_o == 4'hF)
    else $error("enable shape"); // R9
  AST_READ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wr_op_i) |=> $stable(valid_o) && $stable(way_o))
    else $error("read op touched port"); // R6
  AST_INV_NOWAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> way_o == 2'b00) else $error("stale way"); // R1
endmodule

// File: tb/way_memo_top_bench.sv
module way_memo_top_bench;
  localparam int CLK_PER = 10;
  localparam int N = 64;
  logic clk = 0, rst_ni = 0;
  logic req = 0, wr = 0, upd = 0, ld = 0, inv = 0;
  logic [5:0] idx = 0, iidx = 0;
  logic [1:0] l2w = 0;
  logic valid; logic [1:0] way; logic [3:0] en;
  int runs = 0, fails = 0;
  logic       m_v [N];
  logic [1:0] m_w [N];
  logic [1:0] m_reg;

  always #(CLK_PER/2) clk = ~clk;

  way_memo_top u_way_memo_top (
    .clk_i(clk), .rst_ni, .req_i(req), .wr_op_i(wr), .upd_i(upd), .idx_i(idx),
    .way_ld_i(ld), .l2_way_i(l2w), .inv_i(inv), .inv_idx_i(iidx),
    .valid_o(valid), .way_o(way), .way_en_o(en)
  );

  function automatic logic [3:0] exp_en(logic v, logic [1:0] w);
    return v ? 4'b1 << w : 4'hF;
  endfunction

  task automatic chk(string r, logic v, logic [1:0] w);
    runs++;
    if (valid !== v || way !== w || en !== exp_en(v, w)) begin
      fails++;
      $display("FAIL %s: got v=%b w=%b en=%b exp v=%b w=%b en=%b",
               r, valid, way, en, v, w, exp_en(v, w));
    end
  endtask

  task automatic idle();
    req = 0; ld = 0; inv = 0; upd = 0; wr = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic fill(logic [5:0] i, logic [1:0] w, logic load);
    req = 1; wr = 1; upd = 1; idx = i; ld = load; l2w = w;
    if (load) m_reg = w;
    m_v[i] = 1; m_w[i] = m_reg;
    step();
  endtask

  task automatic look(logic [5:0] i, string r);
    req = 1; wr = 1; upd = 0; idx = i;
    step();
    chk(r, m_v[i], m_v[i] ? m_w[i] : 2'b00);
  endtask

  task automatic kill(logic [5:0] i);
    inv = 1; iidx = i; m_v[i] = 0;
    step();
  endtask

  initial begin
    #(CLK_PER * 20000);
    fails++; runs++;
    $display("FAIL watchdog");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_w[i] = 0; end
    m_reg = 0;
    #(CLK_PER * 2 + 1); rst_ni = 1; #CLK_PER;
    look(6'd0, "R1"); look(6'd63, "R1");
    // way register then separate fill
    ld = 1; l2w = 2'b10; m_reg = 2'b10; step();
    fill(6'd5, 2'b01, 0);
    look(6'd5, "R4");               // expects 10, not 01
    fill(6'd7, 2'b11, 1); look(6'd7, "R4 bypass");
    for (int w = 0; w < 4; w++) begin
      fill(6'(w + 10), 2'(w), 1); look(6'(w + 10), "R5");
    end
    look(6'd6, "R8 neighbour");
    // L1 read leaves outputs and entries alone
    look(6'd7, "R2");
    req = 1; wr = 0; upd = 1; idx = 6'd7; ld = 1; l2w = 2'b00; m_reg = 2'b00; step();
    chk("R6 read quiet", 1, 2'b11);
    look(6'd7, "R6 entry kept");
    // invalidate and fill/inv collision
    kill(6'd7); look(6'd7, "R7");
    req = 1; wr = 1; upd = 1; idx = 6'd20; ld = 1; l2w = 2'b01;
    inv = 1; iidx = 6'd20; m_reg = 2'b01; m_v[20] = 1; m_w[20] = 2'b01; step();
    look(6'd20, "R7 fill wins");
    // hold: idle cycle keeps output
    step(); chk("R2 hold", 1, 2'b01);
    for (int k = 0; k < 2000; k++) begin
      int op = $urandom_range(0, 9);
      logic [5:0] i = 6'($urandom);
      if (op < 4) fill(i, 2'($urandom), 1'($urandom));
      else if (op < 5) kill(i);
      else look(i, "R3 random");
    end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule